// File: doc/BRIEF.md
# Two-Vector Matrix Transpose Shuffle Unit

The unit rearranges the elements of two 512-bit vectors. The two operands are joined into one 1024-bit value, with `lhs_i` holding the lower-numbered elements. That value is read as a row-major matrix of r rows and c columns of w-bit elements, and the matrix is transposed. A half-select bit then picks either the low or the high 512 bits of the transposed result. A second kind of mode uses `lhs_i` alone: it swaps every adjacent pair of 16-bit elements.

A 6-bit mode code selects the element width, the matrix shape and the half. The shuffle network itself is pure wiring followed by one wide multiplexer. The result is captured in one output register, so each answer appears one clock after its operands and mode are presented. Software-visible state does not exist.

Top module: `vec_transpose_shuffle`

## Requirements
- R1: A rising clock edge that samples `rst_n` low clears `result_o` to all zeros.
- R2: `result_o` shows the result for the operands and mode sampled at the previous rising edge, and it holds that value until the next edge.
- R3: For mode codes 0 to 31, bits [4:1] give a shape index and bit 0 is the half-select, where 0 means low and 1 means high. The shapes by index, as width/rows x cols, are:
  - 0 = 8/64x2, 1 = 8/2x64
  - 2 = 16/32x2, 3 = 16/2x32, 4 = 16/16x4, 5 = 16/4x16
  - 6 = 32/16x2, 7 = 32/2x16, 8 = 32/8x4, 9 = 32/4x8
  - 10 = 64/8x2, 11 = 64/2x8
  - 12 = 128/4x2, 13 = 128/2x4
  - 14 = 256/2x2, 15 = 512/1x2
- R4: Number the elements of `{rhs_i, lhs_i}` from the least significant end, so that lhs element k is element k. Transposed element p, counted from the least significant end of the 1024-bit result, is then source element (p mod r)*c + p div r.
- R5: With half-select 0, output lane k carries transposed element k. With half-select 1, it carries transposed element k + N/2, where N = 1024/w.
- R6: Mode code 32 sets 16-bit output lane 2i to `lhs_i` lane 2i+1 and lane 2i+1 to `lhs_i` lane 2i, for i = 0 to 15.
- R7: In mode 32 the value of `rhs_i` has no effect on `result_o`.
- R8: Mode codes 33 to 63 produce an all-zero result.
- R9: Mode 30 (512-bit, low) returns `lhs_i` unchanged, and mode 31 (512-bit, high) returns `rhs_i` unchanged.
- R10: In mode 18 (32-bit 4x8, low), 32-bit output lanes 4b to 4b+3 hold source elements b, b+8, b+16 and b+24 for b = 0 to 3. Mode 19 gives the same pattern for b = 4 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the result register |
| lhs_i | input | 512 | First operand, low half of the joined vector |
| rhs_i | input | 512 | Second operand, high half of the joined vector |
| mode_i | input | 6 | Mode code: shape index and half-select, or pair-swap |
| result_o | output | 512 | Registered shuffle result |

## Verification
Every one of the 32 transpose codes is driven with random data and compared against a reference model, since each code has its own wiring. A wrong shape table entry or a swapped row/column rule garbles exactly one code, and a reversed half-select returns the other 512 bits. The degenerate 512-bit 1x2 shape and an index-patterned 32-bit 4x8 case are checked directly: an error in operand order shows up there as lhs and rhs trading places. The pair-swap mode is run twice with the same lhs and different rhs, to catch a design that leaks rhs into that path or swaps along the wrong element boundary. Unused codes, mid-run reset and the one-cycle latency are probed as well, because a design that decodes loosely aliases spare codes onto real shapes.

// File: rtl/vts_pkg.sv
// Package: shared widths, mode code constants and the table of transpose
// shapes. Assumes the operand width is fixed at 512 bits.
package vts_pkg;
    localparam int VEC_W      = 512;
    localparam int DBL_W      = 2 * VEC_W;
    localparam int NUM_SHAPES = 16;
    localparam int MODE_W     = 6;
    localparam int SHAPE_IDX_W = $clog2(NUM_SHAPES);
    localparam logic [MODE_W-1:0] FLIP_CODE = MODE_W'(2 * NUM_SHAPES);
    localparam int FLIP_EW    = 16;

    // Element width in bits of a shape index.
    function automatic int shape_ew(input int s);
        case (s)
            0, 1:            return 8;
            2, 3, 4, 5:      return 16;
            6, 7, 8, 9:      return 32;
            10, 11:          return 64;
            12, 13:          return 128;
            14:              return 256;
            default:         return 512;
        endcase
    endfunction

    // Row count of a shape index; columns follow from DBL_W.
    function automatic int shape_rows(input int s);
        case (s)
            0:               return 64;
            2:               return 32;
            4, 6:            return 16;
            8, 10:           return 8;
            5, 9, 12:        return 4;
            15:              return 1;
            default:         return 2;
        endcase
    endfunction
endpackage

// File: rtl/vts_transpose.sv
// Module: fixed-shape transpose of the joined 1024-bit vector, both halves.
// Assumes EW * ROWS divides DBL_W. Pure wiring, no logic.
module vts_transpose #(
    parameter int EW   = 32,
    parameter int ROWS = 4
) (
    input  logic [vts_pkg::DBL_W-1:0] src_i,
    output logic [vts_pkg::VEC_W-1:0] lo_o,
    output logic [vts_pkg::VEC_W-1:0] hi_o
);
    import vts_pkg::*;

    localparam int NELEM = DBL_W / EW;
    localparam int COLS  = NELEM / ROWS;
    localparam int HALF  = NELEM / 2;

    // Source element feeding transposed position p.
    function automatic int src_of(input int p);
        return (p % ROWS) * COLS + p / ROWS;
    endfunction

    // One lane of each half per iteration.
    for (genvar k = 0; k < HALF; k++) begin : g_lane
        localparam int SL = src_of(k);
        localparam int SH = src_of(k + HALF);
        assign lo_o[k*EW +: EW] = src_i[SL*EW +: EW];
        assign hi_o[k*EW +: EW] = src_i[SH*EW +: EW];
    end
endmodule

// File: rtl/vts_pair_flip.sv
// Module: swaps each adjacent pair of 16-bit elements of one vector.
// Assumes VEC_W is a multiple of 2*FLIP_EW.
module vts_pair_flip (
    input  logic [vts_pkg::VEC_W-1:0] vec_i,
    output logic [vts_pkg::VEC_W-1:0] vec_o
);
    import vts_pkg::*;

    localparam int NPAIR = VEC_W / (2 * FLIP_EW);

    // Cross-wire the two elements of every pair.
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        assign vec_o[(2*i)*FLIP_EW   +: FLIP_EW] = vec_i[(2*i+1)*FLIP_EW +: FLIP_EW];
        assign vec_o[(2*i+1)*FLIP_EW +: FLIP_EW] = vec_i[(2*i)*FLIP_EW   +: FLIP_EW];
    end
endmodule

// File: rtl/vec_transpose_shuffle.sv
// Module: two-vector transpose shuffle with a registered 512-bit result.
// Every shape is built as fixed wiring; the mode code picks one output
// through a single wide mux into the result register. Codes above the
// pair-swap code give zero. Assumes a synchronous active-low reset.
module vec_transpose_shuffle (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [vts_pkg::VEC_W-1:0]  lhs_i,
    input  logic [vts_pkg::VEC_W-1:0]  rhs_i,
    input  logic [vts_pkg::MODE_W-1:0] mode_i,
    output logic [vts_pkg::VEC_W-1:0]  result_o
);
    import vts_pkg::*;

    logic [DBL_W-1:0] joined;
    logic [VEC_W-1:0] lo_vec [NUM_SHAPES];
    logic [VEC_W-1:0] hi_vec [NUM_SHAPES];
    logic [VEC_W-1:0] flip_vec;
    logic [VEC_W-1:0] next_result;
    logic [SHAPE_IDX_W-1:0] shape_sel;
    logic half_sel;

    assign joined    = {rhs_i, lhs_i};
    assign shape_sel = mode_i[SHAPE_IDX_W:1];
    assign half_sel  = mode_i[0];

    // One transpose network per supported shape.
    for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_shape
        vts_transpose #(
            .EW   (shape_ew(s)),
            .ROWS (shape_rows(s))
        ) u_tr (
            .src_i (joined),
            .lo_o  (lo_vec[s]),
            .hi_o  (hi_vec[s])
        );
    end

    vts_pair_flip u_flip (
        .vec_i (lhs_i),
        .vec_o (flip_vec)
    );

    // Decode the mode code into the selected shuffle output.
    always_comb begin
        next_result = '0;
        if (mode_i < FLIP_CODE) begin
            next_result = half_sel ? hi_vec[shape_sel] : lo_vec[shape_sel];
        end else if (mode_i == FLIP_CODE) begin
            next_result = flip_vec;
        end
    end

    // Capture the result; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else begin
            result_o <= next_result;
        end
    end
endmodule

// File: rtl/vts_checker.sv
// Module: property checker for vec_transpose_shuffle, bound to every
// instance. Observes ports only.
module vts_checker (
    input logic                       clk,
    input logic                       rst_n,
    input logic [vts_pkg::VEC_W-1:0]  lhs_i,
    input logic [vts_pkg::VEC_W-1:0]  rhs_i,
    input logic [vts_pkg::MODE_W-1:0] mode_i,
    input logic [vts_pkg::VEC_W-1:0]  result_o
);
    logic rst_seen_low;

    // Remember whether the previous edge sampled reset.
    always_ff @(posedge clk) rst_seen_low <= !rst_n;

    // R1: an edge in reset leaves a zero result.
    always_ff @(posedge clk) begin
        if (rst_seen_low) begin
            a_r1_reset_clears: assert (result_o == '0);
        end
    end

    a_r6_pair_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 6'd32) |->
        (result_o[15:0] == $past(lhs_i[31:16]) &&
         result_o[31:16] == $past(lhs_i[15:0]) &&
         result_o[511:496] == $past(lhs_i[495:480])));

    a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) > 6'd32) |-> result_o == '0);

    a_r9_wide_lo_is_lhs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 6'd30) |-> result_o == $past(lhs_i));

    a_r9_wide_hi_is_rhs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 6'd31) |-> result_o == $past(rhs_i));

    a_r10_block_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 6'd18) |->
        (result_o[31:0] == $past(lhs_i[31:0]) &&
         result_o[63:32] == $past(lhs_i[287:256]) &&
         result_o[95:64] == $past(rhs_i[31:0])));
endmodule

bind vec_transpose_shuffle vts_checker u_vts_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .lhs_i    (lhs_i),
    .rhs_i    (rhs_i),
    .mode_i   (mode_i),
    .result_o (result_o)
);

// File: tb/tb_vec_transpose_shuffle.sv
`timescale 1ns/1ps
module tb_vec_transpose_shuffle;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] lhs = '0;
    logic [511:0] rhs = '0;
    logic [5:0]   mode = '0;
    logic [511:0] result_o;
    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vec_transpose_shuffle dut (
        .clk(clk), .rst_n(rst_n), .lhs_i(lhs), .rhs_i(rhs),
        .mode_i(mode), .result_o(result_o)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Behavioural reference built from the requirement text (R3 to R8).
    function automatic logic [511:0] model(logic [511:0] l, logic [511:0] r, logic [5:0] m);
        logic [1023:0] cat;
        logic [511:0] o;
        int ew, rows, n, cols, s, h, p, src;
        int ew_t[16]  = '{8,8,16,16,16,16,32,32,32,32,64,64,128,128,256,512};
        int row_t[16] = '{64,2,32,2,16,4,16,2,8,4,8,2,4,2,2,1};
        cat = {r, l};
        o = '0;
        if (m == 6'd32) begin
            for (int i = 0; i < 32; i++) o[i*16 +: 16] = l[(i ^ 1)*16 +: 16];
        end else if (m < 6'd32) begin
            s = int'(m) / 2; h = int'(m) % 2;
            ew = ew_t[s]; rows = row_t[s];
            n = 1024 / ew; cols = n / rows;
            for (int k = 0; k < 512 / ew; k++) begin
                p = h * (n / 2) + k;
                src = (p % rows) * cols + p / rows;
                for (int b = 0; b < ew; b++) o[k*ew + b] = cat[src*ew + b];
            end
        end
        return o;
    endfunction

    task automatic check(string req, logic [511:0] exp);
        n_checks++;
        if (result_o !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, result_o, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next fall.
    task automatic run(logic [511:0] l, logic [511:0] r, logic [5:0] m, string req);
        lhs = l; rhs = r; mode = m;
        @(negedge clk);
        check(req, model(l, r, m));
    endtask

    initial begin
        logic [511:0] a, b, c, fl;
        repeat (2) @(negedge clk);
        lhs = rnd512(); rhs = rnd512(); mode = 6'd5;
        @(negedge clk);
        check("R1 reset clears", '0);
        rst_n = 1'b1;

        // R3 R4 R5: every transpose code, two random data sets each
        for (int m = 0; m < 32; m++) begin
            run(rnd512(), rnd512(), 6'(m), $sformatf("R4/R5 mode %0d", m));
            run(rnd512(), rnd512(), 6'(m), $sformatf("R3 mode %0d", m));
        end

        // R6 R7: pair swap, rhs varied
        a = rnd512();
        run(a, rnd512(), 6'd32, "R6 pair swap");
        fl = result_o;
        run(a, ~rhs, 6'd32, "R7 rhs ignored");
        n_checks++;
        if (result_o !== fl) begin
            n_fail++;
            $display("FAIL R7 actual=%h expected=%h", result_o, fl);
        end

        // R8: spare codes
        run(rnd512(), rnd512(), 6'd33, "R8 code 33");
        run(rnd512(), rnd512(), 6'd47, "R8 code 47");
        run(rnd512(), rnd512(), 6'd63, "R8 code 63");

        // R9: 512-bit shape passes operands through
        a = rnd512(); b = rnd512();
        lhs = a; rhs = b; mode = 6'd30;
        @(negedge clk); check("R9 lo is lhs", a);
        mode = 6'd31;
        @(negedge clk); check("R9 hi is rhs", b);

        // R10: 32-bit 4x8 with index-valued lanes
        for (int i = 0; i < 16; i++) begin
            a[i*32 +: 32] = 32'(i); b[i*32 +: 32] = 32'(16 + i);
        end
        for (int i = 0; i < 16; i++) c[i*32 +: 32] = 32'((i / 4) + 8 * (i % 4));
        lhs = a; rhs = b; mode = 6'd18;
        @(negedge clk); check("R10 4x8 lo", c);
        for (int i = 0; i < 16; i++) c[i*32 +: 32] = 32'(4 + (i / 4) + 8 * (i % 4));
        mode = 6'd19;
        @(negedge clk); check("R10 4x8 hi", c);

        // R2: output holds until the next rising edge
        a = rnd512(); b = rnd512();
        run(a, b, 6'd9, "R2 first value");
        fl = result_o;
        lhs = rnd512(); rhs = rnd512(); mode = 6'd2;
        #5;
        check("R2 holds before edge", fl);
        @(negedge clk);
        check("R2 updates after edge", model(lhs, rhs, mode));

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", '0);
        rst_n = 1'b1;
        run(rnd512(), rnd512(), 6'd0, "R4 after reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule